// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words in the common single-precision layout. Bit 31 holds the sign, bits 30 to 23 hold an exponent biased by 127, and bits 22 to 0 hold the fraction of a significand whose leading one is implied. A request is presented with `in_valid_i` high. `op_sub_i` selects subtraction, which inverts the sign of the second operand. The registered result appears one clock later, together with overflow and underflow flags.

Inside, the block classifies both operands. An operand with a stored exponent of 0 is taken as zero, and any fraction it carries is ignored. When no special operand is present, the significand with the smaller exponent is shifted right to line up with the other. Guard, round and sticky bits are kept through that shift. The signed magnitudes are then added and the sum is renormalized. The result is rounded to nearest, with ties going to the even value. Results outside the normal exponent range are replaced by signed infinity or signed zero, and the matching flag is raised. Infinity and NaN inputs follow a short set of pass-through rules.

Top module: `fp32_addsub`

## Requirements
- R1: Operand fields are sign in bit 31, biased exponent in bits 30..23 (bias 127) and fraction in bits 22..0. For normal operands (stored exponent 1..254) the result is the correctly rounded sum of (1.fraction)×2^(exp−127) values, encoded in the same layout.
- R2: When op_sub_i is 1 the sign of operand b is inverted before the addition path, so the result is a − b.
- R3: A stored exponent of 0 marks an operand as zero whatever its fraction. If exactly one operand is zero, the result is the other operand (with the subtraction sign inversion applied to b). If both are zero, the result is a zero whose sign is the AND of the two effective signs. Neither flag is raised.
- R4: The smaller-exponent significand is right-aligned by the exponent difference. The discarded bits are kept as guard, round and sticky, and the result is rounded to nearest with ties to an even fraction LSB.
- R5: A carry out of the significand sum shifts the result right once and increments the exponent. Leading zeros shift it left and decrement the exponent. An exact cancellation gives +0 (0x00000000).
- R6: A carry out of rounding renormalizes once more: the fraction becomes 0 and the exponent increments.
- R7: If the final unbiased exponent exceeds 127 (stored exponent ≥ 255), the result is signed infinity (exponent 0xFF, fraction 0) and ovf_o is 1.
- R8: If the final unbiased exponent is below −126 (stored exponent ≤ 0), the result is a zero carrying the result sign and unf_o is 1.
- R9: Any operand with exponent 0xFF and a nonzero fraction, or infinities of opposite effective sign, gives the quiet NaN 0x7FC00000. Otherwise an infinite operand gives an infinity with that operand's effective sign. Specials never raise a flag.
- R10: out_valid_o equals in_valid_i delayed by one clock. Result and flags register on the edge where in_valid_i is 1. Reset clears out_valid_o, result_o, ovf_o and unf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operands are present this cycle |
| op_sub_i | input | 1 | 1 selects a − b, 0 selects a + b |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| out_valid_o | output | 1 | Result registered from the previous cycle's request |
| result_o | output | 32 | Sum or difference |
| ovf_o | output | 1 | Result overflowed to infinity |
| unf_o | output | 1 | Result underflowed to zero |

## Verification
Several properties are checked on every cycle: the one-cycle valid latency, the infinity encoding under overflow, the zero encoding under underflow, the two flags never being raised together, exact cancellation landing on +0, and any NaN output taking its canonical form. Correct rounding cannot be shown by a per-cycle property. This covers ties to even, the round-up carry, sticky collection over large exponent gaps, and renormalization after deep cancellation. The same holds for the zero-bypass and infinity pass-through choices. These behaviours are shown only by the bench scenarios, which compare against an exact wide-integer reference model.

// File: rtl/fp32_addsub_pkg.sv
package fp32_addsub_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;          // hidden one restored
  localparam int EXT_W  = SIG_W + 3;           // plus guard, round, sticky
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  sig;
    logic              is_zero;
    logic              is_inf;
    logic              is_nan;
  } unp_t;

  // count of leading zeros; all-zero input returns EXT_W
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    lead_zeros = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) lead_zeros = LZ_W'(EXT_W - 1 - i);
  endfunction
endpackage

// File: rtl/fp32_addsub_unpack.sv
module fp32_addsub_unpack
  import fp32_addsub_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              flip_i,
  output unp_t              op_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f        = word_i[FRAC_W +: EXP_W];
    frac_f       = word_i[FRAC_W-1:0];
    op_o.sign    = word_i[WORD_W-1] ^ flip_i;            // R2 sign inversion
    op_o.exp     = exp_f;
    op_o.sig     = {1'b1, frac_f};
    op_o.is_zero = (exp_f == '0);                        // R3 flush to zero
    op_o.is_inf  = (exp_f == '1) && (frac_f == '0);
    op_o.is_nan  = (exp_f == '1) && (frac_f != '0);
  end
endmodule

// File: rtl/fp32_addsub_align_add.sv
module fp32_addsub_align_add
  import fp32_addsub_pkg::*;
(
  input  unp_t             x_i,
  input  unp_t             y_i,
  output logic [EXT_W:0]   sum_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             sign_o,
  output logic             sum_zero_o
);
  localparam int ALN_W  = SIG_W + 2;
  localparam int WIDE_W = ALN_W + SIG_W;

  unp_t              big, sml;
  logic [EXP_W-1:0]  diff;
  logic [WIDE_W-1:0] wide;
  logic [ALN_W-1:0]  aln;
  logic              stk;
  logic [EXT_W:0]    big_ext, sml_ext;

  always_comb begin
    if ({x_i.exp, x_i.sig} >= {y_i.exp, y_i.sig}) begin
      big = x_i; sml = y_i;
    end else begin
      big = y_i; sml = x_i;
    end
    diff = big.exp - sml.exp;
    // R4: right alignment, bits shifted past round collapse into sticky
    if (diff >= EXP_W'(WIDE_W)) begin
      wide = '0;
      stk  = 1'b1;
    end else begin
      wide = {sml.sig, {ALN_W{1'b0}}} >> diff;
      stk  = |wide[SIG_W-1:0];
    end
    aln     = wide[WIDE_W-1 -: ALN_W];
    big_ext = {1'b0, big.sig, 3'b000};
    sml_ext = {1'b0, aln, stk};
    sum_o   = (big.sign ^ sml.sign) ? big_ext - sml_ext : big_ext + sml_ext;
    exp_o   = big.exp;
    sign_o  = big.sign;
    sum_zero_o = (sum_o == '0);
  end
endmodule

// File: rtl/fp32_addsub_norm_round.sv
module fp32_addsub_norm_round
  import fp32_addsub_pkg::*;
(
  input  logic [EXT_W:0]    sum_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              sign_i,
  output logic [WORD_W-1:0] res_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              norm_msb_o
);
  logic [LZ_W-1:0]         lz;
  logic [EXT_W-1:0]        nsum;
  logic signed [EXP_W+1:0] e_norm, e_fin;
  logic                    up;
  logic [SIG_W:0]          rsig;
  logic [FRAC_W-1:0]       frac;

  always_comb begin
    lz = lead_zeros(sum_i[EXT_W-1:0]);
    // R5: renormalize
    if (sum_i[EXT_W]) begin
      nsum   = {sum_i[EXT_W:2], sum_i[1] | sum_i[0]};
      e_norm = $signed({2'b00, exp_i}) + 10'sd1;
    end else begin
      nsum   = sum_i[EXT_W-1:0] << lz;
      e_norm = $signed({2'b00, exp_i}) - $signed({{(EXP_W+2-LZ_W){1'b0}}, lz});
    end
    norm_msb_o = nsum[EXT_W-1];
    // R4: nearest, ties to even
    up   = nsum[2] & (nsum[1] | nsum[0] | nsum[3]);
    rsig = {1'b0, nsum[EXT_W-1:3]} + (SIG_W+1)'(up);
    // R6: rounding carry
    if (rsig[SIG_W]) begin
      frac  = '0;
      e_fin = e_norm + 10'sd1;
    end else begin
      frac  = rsig[FRAC_W-1:0];
      e_fin = e_norm;
    end
    ovf_o = 1'b0;
    unf_o = 1'b0;
    if (e_fin >= EXP_MAX) begin                 // R7
      ovf_o = 1'b1;
      res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (e_fin <= 0) begin              // R8
      unf_o = 1'b1;
      res_o = {sign_i, {(WORD_W-1){1'b0}}};
    end else begin
      res_o = {sign_i, e_fin[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fp32_addsub_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              op_sub_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o,
  output logic              unf_o
);
  unp_t              ua, ub;
  logic [EXT_W:0]    sum;
  logic [EXP_W-1:0]  exp_big;
  logic              sign_big, sum_zero, norm_msb;
  logic [WORD_W-1:0] arith_res, nxt_res;
  logic              arith_ovf, arith_unf, nxt_ovf, nxt_unf;
  logic              arith_sel;

  fp32_addsub_unpack u_unp_a (.word_i(a_i), .flip_i(1'b0),     .op_o(ua));
  fp32_addsub_unpack u_unp_b (.word_i(b_i), .flip_i(op_sub_i), .op_o(ub));

  fp32_addsub_align_add u_add (
    .x_i(ua), .y_i(ub), .sum_o(sum), .exp_o(exp_big),
    .sign_o(sign_big), .sum_zero_o(sum_zero));

  fp32_addsub_norm_round u_nr (
    .sum_i(sum), .exp_i(exp_big), .sign_i(sign_big),
    .res_o(arith_res), .ovf_o(arith_ovf), .unf_o(arith_unf),
    .norm_msb_o(norm_msb));

  always_comb begin
    nxt_ovf   = 1'b0;
    nxt_unf   = 1'b0;
    arith_sel = 1'b0;
    if (ua.is_nan || ub.is_nan)                          // R9
      nxt_res = QNAN;
    else if (ua.is_inf && ub.is_inf)
      nxt_res = (ua.sign != ub.sign) ? QNAN : {ua.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (ua.is_inf)
      nxt_res = {ua.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (ub.is_inf)
      nxt_res = {ub.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (ua.is_zero && ub.is_zero)                   // R3
      nxt_res = {ua.sign & ub.sign, {(WORD_W-1){1'b0}}};
    else if (ua.is_zero)
      nxt_res = {ub.sign, ub.exp, ub.sig[FRAC_W-1:0]};
    else if (ub.is_zero)
      nxt_res = {ua.sign, ua.exp, ua.sig[FRAC_W-1:0]};
    else if (sum_zero)                                   // R5 exact cancel
      nxt_res = '0;
    else begin
      arith_sel = 1'b1;
      nxt_res   = arith_res;
      nxt_ovf   = arith_ovf;
      nxt_unf   = arith_unf;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      ovf_o       <= 1'b0;
      unf_o       <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;                         // R10
      if (in_valid_i) begin
        result_o <= nxt_res;
        ovf_o    <= nxt_ovf;
        unf_o    <= nxt_unf;
      end
    end
  end

  assert_valid_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_valid_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_ovf_is_inf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  assert_unf_is_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (result_o[WORD_W-2:0] == '0));
  assert_flags_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
  assert_cancel_pos_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !ua.is_nan && !ub.is_nan && !ua.is_inf && !ub.is_inf &&
     !ua.is_zero && !ub.is_zero && sum_zero) |=> (result_o == '0));
  assert_norm_hidden_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && arith_sel) |-> norm_msb);
  assert_nan_canonical_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && result_o[WORD_W-2 -: EXP_W] == '1 && result_o[FRAC_W-1:0] != '0)
      |-> (result_o == QNAN));
endmodule

// File: tb/fp32_addsub_tb_top.sv
module fp32_addsub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;
  localparam logic [31:0] QN = 32'h7FC00000;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0, sub = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        o_vld, o_ovf, o_unf;
  logic [31:0] o_res;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_addsub dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .op_sub_i(sub),
    .a_i(a), .b_i(b), .out_valid_o(o_vld), .result_o(o_res),
    .ovf_o(o_ovf), .unf_o(o_unf));

  // exact reference: {ovf, unf, result}
  function automatic logic [33:0] ref_add(input logic [31:0] x, input logic [31:0] y, input bit s);
    bit sx = x[31], sy = y[31] ^ s;
    int ex = int'(x[30:23]), ey = int'(y[30:23]);
    bit nx = (ex == 255) && (x[22:0] != 0), ny = (ey == 255) && (y[22:0] != 0);
    bit ix = (ex == 255) && (x[22:0] == 0), iy = (ey == 255) && (y[22:0] == 0);
    longint unsigned mx = {41'd1, x[22:0]}, my = {41'd1, y[22:0]};
    longint unsigned mh, ml, vb, vs, v, keep, rem, half;
    int eh, el, d, p, sa, e;
    bit sh, sl;
    if (nx || ny) return {2'b00, QN};
    if (ix && iy) return (sx != sy) ? {2'b00, QN} : {2'b00, sx, 8'hFF, 23'h0};
    if (ix) return {2'b00, sx, 8'hFF, 23'h0};
    if (iy) return {2'b00, sy, 8'hFF, 23'h0};
    if (ex == 0 && ey == 0) return {2'b00, sx & sy, 31'h0};
    if (ex == 0) return {2'b00, sy, y[30:0]};
    if (ey == 0) return {2'b00, sx, x[30:0]};
    if (ex > ey || (ex == ey && mx >= my)) begin
      eh = ex; el = ey; mh = mx; ml = my; sh = sx; sl = sy;
    end else begin
      eh = ey; el = ex; mh = my; ml = mx; sh = sy; sl = sx;
    end
    d  = eh - el;
    vb = mh << 32;
    vs = (d > 30) ? 64'd1 : ((ml << 32) >> d);
    v  = (sh == sl) ? vb + vs : vb - vs;
    if (v == 0) return 34'h0;
    p = 0;
    for (int i = 0; i < 64; i++) if (v[i]) p = i;
    e    = eh + p - 55;
    sa   = p - 23;
    keep = v >> sa;
    rem  = v & ((64'd1 << sa) - 1);
    half = 64'd1 << (sa - 1);
    if (rem > half || (rem == half && keep[0])) keep = keep + 1;
    if (keep == (64'd1 << 24)) begin keep = keep >> 1; e = e + 1; end
    if (e >= 255) return {2'b10, sh, 8'hFF, 23'h0};
    if (e <= 0)   return {2'b01, sh, 31'h0};
    return {2'b00, sh, e[7:0], keep[22:0]};
  endfunction

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp_v);
    n_chk++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got ovf=%b unf=%b res=%h, expected ovf=%b unf=%b res=%h",
               tag, got[33], got[32], got[31:0], exp_v[33], exp_v[32], exp_v[31:0]);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run(input string tag, input logic [31:0] x, input logic [31:0] y,
                     input bit s, input logic [33:0] exp_v);
    @(negedge clk);
    vld = 1'b1; a = x; b = y; sub = s;
    @(negedge clk);
    check(tag, {o_ovf, o_unf, o_res}, exp_v);
    check({tag, " valid"}, {33'h0, o_vld}, 34'h1);
  endtask

  task automatic run_ref(input string tag, input logic [31:0] x, input logic [31:0] y, input bit s);
    run(tag, x, y, s, ref_add(x, y, s));
  endtask

  initial begin
    int unsigned seed_use;
    seed_use = $urandom(32'h1C0FFEE);
    repeat (3) @(negedge clk);
    check("R10 reset", {o_vld, o_ovf, o_unf, o_res}, 35'h0);
    rst_n = 1'b1;
    // R1 / R5 carry
    run("R1 1+1", 32'h3F800000, 32'h3F800000, 0, {2'b00, 32'h40000000});
    run("R1 1.5+2.25", 32'h3FC00000, 32'h40100000, 0, {2'b00, 32'h40700000});
    // R2
    run("R2 1-0.75", 32'h3F800000, 32'h3F400000, 1, {2'b00, 32'h3E800000});
    run("R2 0.75-1", 32'h3F400000, 32'h3F800000, 1, {2'b00, 32'hBE800000});
    // R5 cancel
    run("R5 cancel", 32'hC0A00000, 32'hC0A00000, 1, {2'b00, 32'h00000000});
    run("R5 lshift", 32'h3F800001, 32'h3F800000, 1, {2'b00, 32'h34000000});
    // R3 zero bypass
    run("R3 0+b", 32'h00000000, 32'hC0A00000, 0, {2'b00, 32'hC0A00000});
    run("R3 sub 0-b", 32'h00000000, 32'hC0A00000, 1, {2'b00, 32'h40A00000});
    run("R3 denorm a", 32'h00000123, 32'h3F800000, 0, {2'b00, 32'h3F800000});
    run("R3 a-0", 32'h41200000, 32'h80000000, 1, {2'b00, 32'h41200000});
    run("R3 -0+-0", 32'h80000000, 32'h80000000, 0, {2'b00, 32'h80000000});
    run("R3 +0-+0", 32'h00000000, 32'h00000000, 1, {2'b00, 32'h00000000});
    // R4 ties to even, sticky
    run("R4 tie even down", 32'h3F800000, 32'h33800000, 0, {2'b00, 32'h3F800000});
    run("R4 tie odd up", 32'h3F800001, 32'h33800000, 0, {2'b00, 32'h3F800002});
    run("R4 above tie", 32'h3F800000, 32'h33800001, 0, {2'b00, 32'h3F800001});
    run("R4 far sticky", 32'h3F800000, 32'h0F800000, 1, {2'b00, 32'h3F800000});
    // R6 rounding carry
    run("R6 carry", 32'h3FFFFFFF, 32'h33800000, 0, {2'b00, 32'h40000000});
    // R7 overflow
    run("R7 pos ovf", 32'h7F7FFFFF, 32'h7F7FFFFF, 0, {2'b10, 32'h7F800000});
    run("R7 neg ovf", 32'hFF7FFFFF, 32'h7F7FFFFF, 1, {2'b10, 32'hFF800000});
    // R8 underflow
    run("R8 pos unf", 32'h00800001, 32'h00800000, 1, {2'b01, 32'h00000000});
    run("R8 neg unf", 32'h80800001, 32'h00800000, 0, {2'b01, 32'h80000000});
    // R9 specials
    run("R9 nan in", 32'h7F800001, 32'h3F800000, 0, {2'b00, QN});
    run("R9 inf-inf", 32'h7F800000, 32'h7F800000, 1, {2'b00, QN});
    run("R9 inf+inf", 32'h7F800000, 32'h7F800000, 0, {2'b00, 32'h7F800000});
    run("R9 1-inf", 32'h3F800000, 32'h7F800000, 1, {2'b00, 32'hFF800000});
    // R10 idle cycle drops valid
    @(negedge clk); vld = 1'b0;
    @(negedge clk);
    check("R10 idle", {33'h0, o_vld}, 34'h0);
    // random, against the reference model (R4 rounding across all paths)
    for (int i = 0; i < 3000; i++) begin
      int mode, ea, eb;
      logic [31:0] x, y;
      mode = int'($urandom % 4);
      ea = 1 + int'($urandom % 254);
      eb = ea + int'($urandom % 7) - 3;
      x = {1'($urandom), 8'(ea), 23'($urandom)};
      case (mode)
        0: begin x = $urandom; y = $urandom; end
        1: y = {1'($urandom), 8'((eb < 1) ? 1 : (eb > 254 ? 254 : eb)), 23'($urandom)};
        2: y = {1'($urandom), x[30:23], x[22:0] ^ 23'($urandom % 16)};
        default: begin
          ea = ($urandom % 2) ? 250 + int'($urandom % 5) : 1 + int'($urandom % 4);
          x = {1'($urandom), 8'(ea), 23'($urandom)};
          y = {1'($urandom), 8'(ea + int'($urandom % 3) - 1), 23'($urandom)};
          if (y[30:23] == 8'h00 || y[30:23] == 8'hFF) y[30:23] = x[30:23];
        end
      endcase
      run_ref("R4 random", x, y, 1'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule